// File: doc/BRIEF.md
# Half-Step Capable Clock Output Divider

This block sits after a high-rate oscillator and turns its clock into a slower output clock. A 3-bit ratio code picks one of eight ratios: 1, 1.5, 2, 3, 4, 6, 8 or 12. The output comes as a true/complement pair. Some ratios are odd or half-integer, so the block updates one register on each rising input edge and a second register on each falling input edge. The output is the exclusive-OR of the two. Every output transition therefore falls on an input edge, and any pattern of input half-periods can be formed.

An active-high master reset holds the output pair in its idle state: the true output low and the complement high. The ratio code is taken while reset is held, at the first rising edge after release, and at the end of each output pattern. A code change in the middle of a pattern therefore never cuts an output pulse short. After release, the first rising input edge starts the first output high phase.

Top module: `frac_outdiv`

## Requirements
- R1: While `mrst` is high, `fout` is 0 and `fout_n` is 1. The reset acts without waiting for a clock edge.
- R2: `fout_n` is always the inverse of `fout`.
- R3: Ratio codes 0 to 7 give output periods of 2, 3, 4, 6, 8, 12, 16 and 24 input half-periods, in that order. These are the ratios 1, 1.5, 2, 3, 4, 6, 8 and 12.
- R4: For codes 2, 4, 5, 6 and 7, the output is high for exactly the first half of each period and changes only on rising input edges.
- R5: For code 3 (ratio 3), each 6-half-period cycle is high for its first 3 half-periods and low for the last 3. This gives a 50% duty cycle.
- R6: For code 1 (ratio 1.5), the output repeats the 6-half-period pattern high, high, low, high, low, low. Consecutive periods are high for 2 and then 1 half-periods, which averages 50%.
- R7: For code 0 (ratio 1), the output is high in every high phase of the input clock and low in every low phase.
- R8: The first rising input edge after `mrst` falls drives `fout` high, whatever the code.
- R9: The code on `nsel` is taken at each rising edge while in reset, at the first rising edge after reset, and at the first rising edge of each new pattern. The pattern is one output period, or two output periods for code 1. A change at any other time has no effect until the next pattern starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | High-rate input clock to be divided |
| mrst | input | 1 | Active-high master reset, asynchronous assertion |
| nsel | input | 3 | Ratio code (see R3) |
| fout | output | 1 | Divided clock, true polarity |
| fout_n | output | 1 | Divided clock, complement polarity |

## Verification
The output is sampled in the middle of every input half-period and compared with a pattern that the bench computes for each code. These samples show whether a transition happened on the rising or the falling input edge, which is what separates the even ratios from ratio 3 and ratio 1.5.

For each code, the bench first runs a directed pass from reset. It counts the high half-periods and the rising output edges over 48 half-periods, which checks the ratio and the duty cycle apart from the exact pattern. Directed code switches in the middle of a pattern check that a new code waits for the pattern boundary.

A seeded random phase then changes the code at arbitrary points and sometimes asserts reset mid-stream. This exercises pattern-boundary sampling across every pair of ratios.

// File: rtl/frac_outdiv.sv
module frac_outdiv #(
  parameter int CW = 4
) (
  input  logic       vco_clk,
  input  logic       mrst,
  input  logic [2:0] nsel,
  output logic       fout,
  output logic       fout_n
);

  logic          run;
  logic [CW-1:0] cnt;
  logic [2:0]    code;
  logic          pq;
  logic          nq;

  function automatic logic [CW-1:0] last_of(input logic [2:0] k);
    case (k)
      3'd0:    last_of = CW'(0);
      3'd1:    last_of = CW'(2);
      3'd2:    last_of = CW'(1);
      3'd3:    last_of = CW'(2);
      3'd4:    last_of = CW'(3);
      3'd5:    last_of = CW'(5);
      3'd6:    last_of = CW'(7);
      default: last_of = CW'(11);
    endcase
  endfunction

  function automatic logic hi_of(input logic [2:0] k, input logic [CW-1:0] c);
    case (k)
      3'd0:    hi_of = 1'b1;
      3'd1:    hi_of = (c == '0);
      3'd3:    hi_of = (c <= CW'(1));
      default: hi_of = (c <= (last_of(k) >> 1));
    endcase
  endfunction

  function automatic logic lo_of(input logic [2:0] k, input logic [CW-1:0] c);
    case (k)
      3'd0:    lo_of = 1'b0;
      3'd1:    lo_of = (c <= CW'(1));
      3'd3:    lo_of = (c == '0);
      default: lo_of = (c <= (last_of(k) >> 1));
    endcase
  endfunction

  logic          wrap;
  logic [2:0]    nxt_code;
  logic [CW-1:0] nxt_cnt;

  assign wrap     = !run || (cnt == last_of(code));
  assign nxt_code = wrap ? nsel : code;
  assign nxt_cnt  = wrap ? '0 : cnt + CW'(1);

  always_ff @(posedge vco_clk) begin
    if (mrst || wrap) code <= nsel;
  end

  always_ff @(posedge vco_clk or posedge mrst) begin
    if (mrst) begin
      run <= 1'b0;
      cnt <= '0;
      pq  <= 1'b0;
    end else begin
      run <= 1'b1;
      cnt <= nxt_cnt;
      pq  <= hi_of(nxt_code, nxt_cnt) ^ nq;
    end
  end

  always_ff @(negedge vco_clk or posedge mrst) begin
    if (mrst) nq <= 1'b0;
    else      nq <= lo_of(code, cnt) ^ pq;
  end

  assign fout   = pq ^ nq;
  assign fout_n = ~fout;

endmodule

// File: rtl/frac_outdiv_chk.sv
module frac_outdiv_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          mrst,
  input logic          run,
  input logic [2:0]    code,
  input logic [CW-1:0] cnt,
  input logic          fout,
  input logic          fout_n
);

  logic hi_s;
  always_ff @(negedge clk) hi_s <= fout;

  logic even_code;
  assign even_code = (code == 3'd2) || (code == 3'd4) || (code == 3'd5) ||
                     (code == 3'd6) || (code == 3'd7);

  p_rst_idle_r1: assert property (@(negedge clk) mrst |-> (!fout && fout_n));
  p_rst_idle_pos_r1: assert property (@(posedge clk) mrst |-> (!fout && fout_n));

  p_even_rise_only_r4: assert property (@(posedge clk) disable iff (mrst)
    (run && $past(run) && even_code) |-> (fout == hi_s));

  p_div3_mid_r5: assert property (@(negedge clk) disable iff (mrst)
    (run && code == 3'd3 && cnt == CW'(1)) |-> fout);
  p_div3_mid_low_r5: assert property (@(posedge clk) disable iff (mrst)
    (run && code == 3'd3 && cnt == CW'(1)) |-> !fout);

  p_half_step_r6: assert property (@(negedge clk) disable iff (mrst)
    (run && code == 3'd1 && cnt == CW'(1)) |-> !fout);

  p_div1_high_r7: assert property (@(negedge clk) disable iff (mrst)
    (run && code == 3'd0) |-> fout);
  p_div1_low_r7: assert property (@(posedge clk) disable iff (mrst)
    (run && code == 3'd0) |-> !fout);

  p_code_at_wrap_r9: assert property (@(posedge clk) disable iff (mrst)
    (run && !$stable(code)) |-> (cnt == '0));

endmodule

bind frac_outdiv frac_outdiv_chk #(.CW(CW)) u_chk (
  .clk(vco_clk), .mrst(mrst), .run(run), .code(code),
  .cnt(cnt), .fout(fout), .fout_n(fout_n)
);

// File: tb/tb_frac_outdiv.sv
module tb_frac_outdiv;
  logic       clk = 1'b0;
  logic       mrst;
  logic [2:0] nsel;
  logic       fout, fout_n;

  frac_outdiv dut (.vco_clk(clk), .mrst(mrst), .nsel(nsel), .fout(fout), .fout_n(fout_n));

  always #2 clk = ~clk;

  int    checks = 0, fails = 0;
  int    pos = 0, mcode = 0;
  int    highs = 0, rises = 0;
  bit    prev = 1'b0;
  bit    done = 1'b0;
  string tag = "";

  function automatic int plen(int c);
    case (c)
      0: return 2;  1: return 6;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 24;
    endcase
  endfunction

  function automatic int perh(int c);
    case (c)
      0: return 2;  1: return 3;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 24;
    endcase
  endfunction

  function automatic bit expb(int c, int h);
    if (c == 1) return (h == 0) || (h == 1) || (h == 3);
    return h < plen(c) / 2;
  endfunction

  function automatic string reqtag(int c);
    case (c)
      0: return "R7";
      1: return "R6";
      3: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic meas(input bit s);
    if (s && !prev) rises++;
    if (s) highs++;
    prev = s;
  endtask

  // Entered at mid-high; leaves at the next mid-high.
  task automatic cyc(input logic [2:0] nx, input logic rx);
    bit e;
    string t;
    if (mrst) begin
      chk(fout == 1'b0 && fout_n == 1'b1, "R1", {fout, fout_n}, 1);
      #2;
      chk(fout == 1'b0 && fout_n == 1'b1, "R1", {fout, fout_n}, 1);
      prev = 1'b0;
    end else begin
      if (pos == 0) mcode = int'(nsel);
      t = (tag != "") ? tag : reqtag(mcode);
      e = expb(mcode, pos);
      chk(fout == e, t, fout, e);
      chk(fout_n == !fout, "R2", fout_n, !fout);
      meas(fout);
      #2;
      e = expb(mcode, pos + 1);
      chk(fout == e, t, fout, e);
      chk(fout_n == !fout, "R2", fout_n, !fout);
      meas(fout);
      pos += 2;
      if (pos >= plen(mcode)) pos = 0;
    end
    if (mrst && !rx) pos = 0;
    nsel = nx;
    mrst = rx;
    #2;
  endtask

  initial begin
    mrst = 1'b1;
    nsel = 3'd0;
    #3;
    for (int c = 0; c < 8; c++) begin
      cyc(3'(c), 1'b1);
      cyc(3'(c), 1'b0);
      chk(fout == 1'b1, "R8", fout, 1);
      highs = 0; rises = 0; prev = 1'b0;
      repeat (24) cyc(3'(c), 1'b0);
      chk(highs == 24, reqtag(c), highs, 24);
      chk(rises == 48 / perh(c), "R3", rises, 48 / perh(c));
    end

    cyc(3'd7, 1'b1);
    cyc(3'd7, 1'b0);
    tag = "R9";
    cyc(3'd7, 1'b0);
    cyc(3'd0, 1'b0);
    repeat (14) cyc(3'd0, 1'b0);
    cyc(3'd1, 1'b0);
    cyc(3'd2, 1'b0);
    repeat (10) cyc(3'd2, 1'b0);
    tag = "";

    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] nx;
      logic       rx;
      int unsigned r;
      r  = $urandom;
      nx = (r % 6 == 0) ? 3'($urandom % 8) : nsel;
      if (mrst) rx = (r % 3 == 0) ? 1'b1 : 1'b0;
      else      rx = (r % 151 == 0);
      cyc(nx, rx);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3: watchdog expired, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule